// File: doc/BRIEF.md
# SPI FIFO Pair with Trigger Interrupts

This block is the data buffering stage of an SPI master. It holds a transmit byte FIFO and a receive byte FIFO, 64 entries each. Software writes outgoing bytes through a transmit data port and reads incoming bytes through a receive data port. On the other side, the serial shift engine takes bytes from the transmit FIFO and puts received bytes into the receive FIFO. The serial engine itself lives outside this block.

Software programs a trigger level for each FIFO. It can flush either FIFO with a self-clearing bit and can read the exact fill counts. A sticky interrupt status register gathers level conditions and error events: empty, full, trigger-level, overflow, underrun and transfer-done. Each bit is cleared by writing one to it. The interrupt output is raised whenever a status bit is set and its enable bit is also set.

The register port is a simple single-cycle interface. Read data is combinational from the address. A read of the receive port pops the FIFO on the clock edge that ends the read cycle. The engine side uses single-cycle pop and push strobes.

Top module: `spi_fifo_irq`

## Requirements
- R1: The registers sit at word addresses 0 (FIFO control), 1 (FIFO status counts), 2 (interrupt enable), 3 (interrupt status), 4 (transmit data port) and 5 (receive data port). After reset, control reads 0x00000001, counts read 0, enable reads 0 and `irq` is low.
- R2: Each FIFO holds 64 bytes and delivers them in the order they were accepted. The engine reads the transmit head on `eng_tx_data`, and software reads the receive head at address 5.
- R3: A write to the transmit port while it holds 64 bytes is dropped and sets interrupt status bit 10. An engine push into a full receive FIFO is dropped and sets bit 8.
- R4: A receive port read from an empty receive FIFO returns 0 and sets status bit 9. An engine pop from an empty transmit FIFO presents 0 and sets bit 11.
- R5: The control register holds the transmit trigger level in bits 23:16 and the receive trigger level in bits 7:0, and both read back as written.
- R6: Writing 1 to control bit 31 flushes the transmit FIFO, and writing 1 to bit 15 flushes the receive FIFO. The bit reads 1 for the one cycle after the write and then reads 0 with that FIFO empty.
- R7: The status count register shows the transmit fill count in bits 23:16 and the receive fill count in bits 7:0.
- R8: Status bit 4 (transmit request) is set while the transmit count is less than or equal to the transmit trigger level.
- R9: Status bit 0 (receive ready) is set while the receive count is greater than or equal to the receive trigger level.
- R10: Status bit 1 marks receive empty, bit 2 receive full, bit 5 transmit empty and bit 6 transmit full. Right after reset the status register reads 0x32.
- R11: A pulse on `eng_done` sets status bit 12 (transfer complete).
- R12: Status bits appear one cycle after their cause. Writing 1 to a status bit clears it in the next cycle. A level condition that is still true sets the bit again one cycle later, while a cleared event bit stays clear.
- R13: `irq` is high exactly when some status bit is set together with its enable bit at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 5) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_avail | output | 1 | Transmit FIFO is not empty |
| eng_tx_data | output | 8 | Transmit head byte, 0 when empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_done | input | 1 | Transfer-complete pulse from the engine |
| irq | output | 1 | Interrupt request |

## Verification
Byte streams of different lengths run through both FIFOs: a short burst, a 65-byte overfill and a single byte after a flush. A queue-based scoreboard checks that order is kept and that the overflowing byte is really dropped, not written over the head. Pops and reads on empty FIFOs show that underrun returns 0 and is flagged, as distinct from a normal data read. Trigger levels are tested by clearing the request flag with the count just above the level, then moving the count onto the level. This tells the inclusive compare apart from a strict one. Write-one-to-clear is tried at the same moment on a persisting level bit and on an event bit, which shows the re-set behaviour apart from plain sticky behaviour.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  // register word addresses
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_STAT = 3'd1;
  localparam logic [REG_AW-1:0] A_IEN  = 3'd2;
  localparam logic [REG_AW-1:0] A_ISTS = 3'd3;
  localparam logic [REG_AW-1:0] A_TXD  = 3'd4;
  localparam logic [REG_AW-1:0] A_RXD  = 3'd5;

  // interrupt status bit positions
  localparam int STS_W       = 13;
  localparam int B_RX_RDY    = 0;
  localparam int B_RX_EMPTY  = 1;
  localparam int B_RX_FULL   = 2;
  localparam int B_TX_REQ    = 4;
  localparam int B_TX_EMPTY  = 5;
  localparam int B_TX_FULL   = 6;
  localparam int B_RX_OVF    = 8;
  localparam int B_RX_UDR    = 9;
  localparam int B_TX_OVF    = 10;
  localparam int B_TX_UDR    = 11;
  localparam int B_XFER_DONE = 12;

  // control register field positions
  localparam int TRIG_W      = 8;
  localparam int C_TX_FLUSH  = 31;
  localparam int C_TX_TRIG   = 16;
  localparam int C_RX_FLUSH  = 15;
  localparam int C_RX_TRIG   = 0;

  localparam logic [TRIG_W-1:0] TX_TRIG_RST = 8'h00;
  localparam logic [TRIG_W-1:0] RX_TRIG_RST = 8'h01;
endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok, mem_we;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    empty   = (cnt_q == '0);
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    mem_we  = push_ok && !flush;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = adv(wr_q);
      if (pop_ok)  rd_d = adv(rd_q);
      cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int NB = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set,
  input  logic [NB-1:0] clr,
  input  logic [NB-1:0] enable,
  output logic [NB-1:0] sts,
  output logic          irq
);
  logic [NB-1:0] sts_q, sts_d;
  logic          sts_en;

  always_comb begin
    sts_d  = (sts_q | set) & ~clr;
    sts_en = |(sts_d ^ sts_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign sts = sts_q;
  assign irq = |(sts_q & enable);
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        eng_tx_pop,
  output logic        eng_tx_avail,
  output logic [7:0]  eng_tx_data,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  input  logic        eng_done,
  output logic        irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int DW    = 8;

  logic rst_sync_n;

  // register state
  logic [TRIG_W-1:0] tx_trig_q, tx_trig_d, rx_trig_q, rx_trig_d;
  logic              tx_pend_q, tx_pend_d, rx_pend_q, rx_pend_d;
  logic [STS_W-1:0]  ien_q, ien_d;
  logic              ctrl_en, ien_en;

  // decode
  logic wr_ctrl, wr_ien, wr_ists, wr_txd, rd_rxd;

  // fifo side
  logic [DW-1:0]    tx_head, rx_head;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;

  // status
  logic [STS_W-1:0] sts_set, sts_clr, sts;
  logic             wdata_unused;

  spi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    wr_ien  = reg_wr && (reg_addr == A_IEN);
    wr_ists = reg_wr && (reg_addr == A_ISTS);
    wr_txd  = reg_wr && (reg_addr == A_TXD);
    rd_rxd  = reg_rd && (reg_addr == A_RXD);
  end

  // next state of software registers
  always_comb begin
    ctrl_en   = wr_ctrl;
    tx_trig_d = reg_wdata[C_TX_TRIG +: TRIG_W];
    rx_trig_d = reg_wdata[C_RX_TRIG +: TRIG_W];
    tx_pend_d = wr_ctrl && reg_wdata[C_TX_FLUSH];
    rx_pend_d = wr_ctrl && reg_wdata[C_RX_FLUSH];
    ien_en    = wr_ien;
    ien_d     = reg_wdata[STS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_trig_q <= TX_TRIG_RST;
      rx_trig_q <= RX_TRIG_RST;
      tx_pend_q <= 1'b0;
      rx_pend_q <= 1'b0;
      ien_q     <= '0;
    end else begin
      if (ctrl_en) begin
        tx_trig_q <= tx_trig_d;
        rx_trig_q <= rx_trig_d;
      end
      tx_pend_q <= tx_pend_d;
      rx_pend_q <= rx_pend_d;
      if (ien_en) ien_q <= ien_d;
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_txq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (tx_pend_q),
    .push      (wr_txd),
    .push_data (reg_wdata[DW-1:0]),
    .pop       (eng_tx_pop),
    .head      (tx_head),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (rx_pend_q),
    .push      (eng_rx_push),
    .push_data (eng_rx_data),
    .pop       (rd_rxd),
    .head      (rx_head),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  // conditions and events feeding the sticky status
  always_comb begin
    sts_set                = '0;
    sts_set[B_RX_RDY]      = TRIG_W'(rx_cnt) >= rx_trig_q;
    sts_set[B_RX_EMPTY]    = rx_empty;
    sts_set[B_RX_FULL]     = rx_full;
    sts_set[B_TX_REQ]      = TRIG_W'(tx_cnt) <= tx_trig_q;
    sts_set[B_TX_EMPTY]    = tx_empty;
    sts_set[B_TX_FULL]     = tx_full;
    sts_set[B_RX_OVF]      = eng_rx_push && rx_full;
    sts_set[B_RX_UDR]      = rd_rxd && rx_empty;
    sts_set[B_TX_OVF]      = wr_txd && tx_full;
    sts_set[B_TX_UDR]      = eng_tx_pop && tx_empty;
    sts_set[B_XFER_DONE]   = eng_done;
    sts_clr                = wr_ists ? reg_wdata[STS_W-1:0] : '0;
  end

  spi_irq_status #(.NB(STS_W)) u_sts (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set    (sts_set),
    .clr    (sts_clr),
    .enable (ien_q),
    .sts    (sts),
    .irq    (irq)
  );

  // read mux
  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {tx_pend_q, 7'b0, tx_trig_q, rx_pend_q, 7'b0, rx_trig_q};
      A_STAT:  reg_rdata = {8'b0, 8'(tx_cnt), 8'b0, 8'(rx_cnt)};
      A_IEN:   reg_rdata = 32'(ien_q);
      A_ISTS:  reg_rdata = 32'(sts);
      A_RXD:   reg_rdata = rx_empty ? 32'd0 : 32'(rx_head);
      default: reg_rdata = 32'd0;
    endcase
  end

  assign eng_tx_avail = !tx_empty;
  assign eng_tx_data  = tx_empty ? 8'd0 : tx_head;
  assign wdata_unused = ^{reg_wdata[30:24], reg_wdata[14:13]};
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             eng_done,
  input logic [CNT_W-1:0] tx_cnt,
  input logic             tx_pend,
  input logic [12:0]      sts,
  input logic [12:0]      ien,
  input logic             irq
);
  AST_TX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(DEPTH)); // R2

  AST_TX_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && tx_cnt == CNT_W'(DEPTH)) |=> sts[10]); // R3

  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pend && !(reg_wr && reg_addr == 3'd0 && reg_wdata[31])) |=> (!tx_pend && tx_cnt == '0)); // R6

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !(reg_wr && reg_addr == 3'd3 && reg_wdata[12])) |=> sts[12]); // R11

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && reg_wdata[12]) |=> !sts[12]); // R12

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R13
endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .eng_done  (eng_done),
  .tx_cnt    (tx_cnt),
  .tx_pend   (tx_pend_q),
  .sts       (sts),
  .ien       (ien_q),
  .irq       (irq)
);

// File: tb/sim_spi_fifo_irq.sv
`timescale 1ns/1ps
module sim_spi_fifo_irq;
  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        eng_tx_pop, eng_tx_avail, eng_rx_push, eng_done, irq;
  logic [7:0]  eng_tx_data, eng_rx_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic [31:0] rv;

  spi_fifo_irq u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] b);
    if (tx_q.size() < 64) tx_q.push_back(b);
    reg_write(3'd4, {24'd0, b});
  endtask

  task automatic rx_read();
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd5;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic eng_pop();
    @(negedge clk);
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    if (rx_q.size() < 64) rx_q.push_back(b);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // scoreboard monitor: compares heads as they are consumed
  always @(negedge clk) begin
    #1;
    if (rst_n && eng_tx_pop)
      chk("R2/R4 tx order", {24'd0, eng_tx_data},
          {24'd0, (tx_q.size() > 0) ? tx_q.pop_front() : 8'd0});
    if (rst_n && reg_rd && reg_addr == 3'd5)
      chk("R2/R4 rx order", reg_rdata,
          {24'd0, (rx_q.size() > 0) ? rx_q.pop_front() : 8'd0});
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0; eng_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(3'd0, rv); chk("R1 ctrl reset", rv, 32'h0000_0001);
    peek(3'd1, rv); chk("R1 counts reset", rv, 32'h0);
    peek(3'd2, rv); chk("R1 enable reset", rv, 32'h0);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    peek(3'd3, rv); chk("R10 status after reset", rv, 32'h0000_0032);

    // R5 trigger fields
    reg_write(3'd0, 32'h0030_0010);
    peek(3'd0, rv); chk("R5 ctrl readback", rv, 32'h0030_0010);

    // R2 R7 short burst
    for (int i = 0; i < 5; i++) tx_write(8'hA0 + 8'(i));
    peek(3'd1, rv); chk("R7 tx count 5", rv, 32'h0005_0000);
    chk("R2 tx avail", {31'd0, eng_tx_avail}, 32'd1);
    for (int i = 0; i < 5; i++) eng_pop();
    peek(3'd1, rv); chk("R7 tx count 0", rv, 32'h0);

    // R3 overfill transmit
    for (int i = 0; i < 65; i++) tx_write(8'((i * 7 + 3) & 8'hFF));
    peek(3'd1, rv); chk("R2 tx depth 64", rv, 32'h0040_0000);
    peek(3'd3, rv);
    chk("R3 tx overflow bit10", {31'd0, rv[10]}, 32'd1);
    chk("R10 tx full bit6", {31'd0, rv[6]}, 32'd1);
    for (int i = 0; i < 64; i++) eng_pop();
    eng_pop(); // R4 pop on empty, monitor expects 0
    peek(3'd3, rv); chk("R4 tx underrun bit11", {31'd0, rv[11]}, 32'd1);

    // receive path
    for (int i = 0; i < 3; i++) eng_push(8'h30 + 8'(i));
    peek(3'd1, rv); chk("R7 rx count 3", rv, 32'h0000_0003);
    for (int i = 0; i < 3; i++) rx_read();
    rx_read(); // R4 read on empty, monitor expects 0
    peek(3'd3, rv); chk("R4 rx underrun bit9", {31'd0, rv[9]}, 32'd1);
    for (int i = 0; i < 65; i++) eng_push(8'(i ^ 8'h5C));
    peek(3'd1, rv); chk("R2 rx depth 64", rv, 32'h0000_0040);
    peek(3'd3, rv);
    chk("R3 rx overflow bit8", {31'd0, rv[8]}, 32'd1);
    chk("R10 rx full bit2", {31'd0, rv[2]}, 32'd1);

    // R6 receive flush
    reg_write(3'd0, 32'h0030_8010);
    peek(3'd0, rv); chk("R6 rx flush bit visible", rv, 32'h0030_8010);
    rx_q.delete();
    @(negedge clk);
    peek(3'd0, rv); chk("R6 rx flush bit cleared", rv, 32'h0030_0010);
    peek(3'd1, rv); chk("R6 rx flushed", rv, 32'h0);

    // R6 transmit flush
    tx_write(8'h11); tx_write(8'h22);
    reg_write(3'd0, 32'h8030_0010);
    peek(3'd0, rv); chk("R6 tx flush bit visible", rv, 32'h8030_0010);
    tx_q.delete();
    @(negedge clk);
    peek(3'd0, rv); chk("R6 tx flush bit cleared", rv, 32'h0030_0010);
    peek(3'd1, rv); chk("R6 tx flushed", rv, 32'h0);
    tx_write(8'h5A);
    eng_pop(); // R6 first byte after flush, monitor expects 0x5A

    // R8 transmit request at or below trigger
    reg_write(3'd0, 32'h0002_0002);
    for (int i = 0; i < 3; i++) tx_write(8'hC0 + 8'(i));
    reg_write(3'd3, 32'h0000_0010);
    @(negedge clk);
    peek(3'd3, rv); chk("R8 no request above trigger", {31'd0, rv[4]}, 32'd0);
    eng_pop();
    @(negedge clk);
    peek(3'd3, rv); chk("R8 request at trigger", {31'd0, rv[4]}, 32'd1);
    eng_pop(); eng_pop();

    // R9 receive ready at or above trigger
    eng_push(8'h71);
    reg_write(3'd3, 32'h0000_0001);
    @(negedge clk);
    peek(3'd3, rv); chk("R9 not ready below trigger", {31'd0, rv[0]}, 32'd0);
    eng_push(8'h72);
    @(negedge clk);
    peek(3'd3, rv); chk("R9 ready at trigger", {31'd0, rv[0]}, 32'd1);
    rx_read(); rx_read();

    // R11 transfer complete
    reg_write(3'd3, 32'h0000_1000);
    pulse_done();
    peek(3'd3, rv); chk("R11 done bit12", {31'd0, rv[12]}, 32'd1);

    // R12 write-one-to-clear
    reg_write(3'd3, 32'h0000_1020);
    peek(3'd3, rv);
    chk("R12 level bit cleared", {31'd0, rv[5]}, 32'd0);
    chk("R12 event bit cleared", {31'd0, rv[12]}, 32'd0);
    @(negedge clk);
    peek(3'd3, rv);
    chk("R12 level bit re-set", {31'd0, rv[5]}, 32'd1);
    chk("R12 event bit stays clear", {31'd0, rv[12]}, 32'd0);

    // R13 interrupt output
    reg_write(3'd2, 32'h0000_1000);
    peek(3'd2, rv); chk("R13 enable readback", rv, 32'h0000_1000);
    chk("R13 irq low with enabled bit clear", {31'd0, irq}, 32'd0);
    pulse_done();
    chk("R13 irq on enabled done", {31'd0, irq}, 32'd1);
    reg_write(3'd3, 32'h0000_1000);
    chk("R13 irq drops after clear", {31'd0, irq}, 32'd0);
    reg_write(3'd2, 32'h0000_0020);
    chk("R13 irq on tx empty", {31'd0, irq}, 32'd1);
    reg_write(3'd2, 32'h0);
    chk("R13 irq masked", {31'd0, irq}, 32'd0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule